// File: doc/BRIEF.md
# RAW Hazard Detect and Forward Unit

This block sits beside the decode stage of an in-order five-stage pipeline. Each cycle it takes the two source register indices of the instruction being decoded. It compares them with the destination indices of the instructions still in flight in the execute, memory and write-back stages. A stage takes part only when its write enable is set.

From those six comparisons it produces four outputs:
- a raw hazard flag;
- one operand-mux select per source, chosen from the youngest matching writer;
- a stall request for the case where forwarding cannot help, namely a value that a load still in execute has not yet fetched.

All outputs are combinational, so decode can be frozen in the same cycle the dependence appears. A build parameter removes the write-back bypass for register files that write early in the cycle and read late. A second parameter sets how many stages a load result stays unavailable.

Top module: `raw_hazard_fwd`

## Requirements
- R1: `raw_hazard` is 1 exactly when `src_a_idx` or `src_b_idx` is nonzero and equals the destination index of at least one of the execute, memory or write-back stages whose write enable is 1.
- R2: Index 0 never matches. A source of 0 always yields select 0 for that operand and causes neither a hazard nor a stall, even when some enabled stage writes index 0.
- R3: When several enabled stages match one operand, the select names the youngest one. Execute beats memory, and memory beats write-back.
- R4: Select encoding per operand: 0 = register file, 1 = execute result, 2 = memory result, 3 = write-back result. With no match, both selects are 0.
- R5: A stage whose write enable is 0 has no effect on any output, whatever its destination index and load flag.
- R6: `load_stall` is 1 when a stage inside the load window (execute only, by default `LOAD_DEPTH`=1) has write enable 1 and load flag 1 and matches either source. A matching load in memory or write-back does not stall and is forwarded.
- R7: All outputs follow input changes within the same cycle, with no clock edge in between.
- R8: With `WB_BYPASS`=0, a match found only in write-back gives select 0, but `raw_hazard` still reports it. Memory and execute matches still forward.
- R9: The two operands are resolved independently. Each select depends only on its own source index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_idx | input | AW | first source register index of the decoding instruction |
| src_b_idx | input | AW | second source register index of the decoding instruction |
| ex_dst_idx | input | AW | destination index held in execute |
| ex_wr_en | input | 1 | execute instruction will write a register |
| ex_is_load | input | 1 | execute instruction is a load |
| mem_dst_idx | input | AW | destination index held in memory stage |
| mem_wr_en | input | 1 | memory-stage instruction will write a register |
| mem_is_load | input | 1 | memory-stage instruction is a load |
| wb_dst_idx | input | AW | destination index held in write-back |
| wb_wr_en | input | 1 | write-back instruction will write a register |
| wb_is_load | input | 1 | write-back instruction is a load |
| sel_a | output | 2 | operand A source select (encoding in R4) |
| sel_b | output | 2 | operand B source select (encoding in R4) |
| load_stall | output | 1 | freeze decode: load result not yet available |
| raw_hazard | output | 1 | any enabled pending write matches a source |

## Verification
The bench targets the following corner cases:

- **Triple match.** One operand matches all three stages at once. A reversed priority chain would forward a stale write-back value instead of the execute result.
- **Register 0.** The bench drives destination and source index 0 with writes enabled. A missing zero guard would show up as a spurious hazard or stall.
- **Load distance.** Loads are placed one and two stages ahead of the consumer. Stalling at the wrong distance either loses data or costs needless bubbles.
- **Disabled writers.** The bench drives stages that match but are not enabled.
- **Split operands.** The two operands hit different stages.
- **No write-back bypass.** A second instance built without the write-back path is driven with a write-back-only match. A variant that still forwarded would pick select 3, and one that dropped the hazard flag would hide the dependence.

// File: rtl/raw_fwd_pkg.sv
package raw_fwd_pkg;

    // Number of in-flight stages that can hold a pending register write.
    localparam int unsigned NUM_STAGES = 3;

    // Stage positions, youngest first; this order is the forwarding priority.
    localparam int unsigned STG_EX  = 0;
    localparam int unsigned STG_MEM = 1;
    localparam int unsigned STG_WB  = 2;

    // Width of an operand select: register file plus one code per stage.
    localparam int unsigned SEL_W = $clog2(NUM_STAGES + 1);

    typedef enum logic [SEL_W-1:0] {
        SRC_REGFILE = 2'd0,
        SRC_EX      = 2'd1,
        SRC_MEM     = 2'd2,
        SRC_WB      = 2'd3
    } opnd_src_e;

endpackage

// File: rtl/raw_stage_match.sv
// Compares one source index against every pending destination.
module raw_stage_match #(
    parameter int unsigned AW    = 5,
    parameter int unsigned NSTG  = 3
) (
    input  logic [AW-1:0]            src_idx,
    input  logic [NSTG-1:0][AW-1:0]  dst_vec,
    input  logic [NSTG-1:0]          wen_vec,
    output logic [NSTG-1:0]          hit_vec
);

    logic src_live;

    // Index 0 is hard-wired to zero and never carries a dependence.
    assign src_live = (src_idx != '0);

    for (genvar s = 0; s < NSTG; s++) begin : g_stage
        assign hit_vec[s] = src_live && wen_vec[s] && (dst_vec[s] == src_idx);
    end

endmodule

// File: rtl/raw_fwd_pick.sv
// Priority select: youngest usable hit wins, else register file.
module raw_fwd_pick #(
    parameter int unsigned NSTG      = 3,
    parameter bit          USE_OLD   = 1'b1,
    localparam int unsigned SW       = $clog2(NSTG + 1)
) (
    input  logic [NSTG-1:0] hit_vec,
    output logic [SW-1:0]   sel
);

    logic [NSTG-1:0] usable;

    for (genvar s = 0; s < NSTG; s++) begin : g_mask
        if (s == NSTG - 1) begin : g_last
            assign usable[s] = hit_vec[s] && USE_OLD;
        end else begin : g_mid
            assign usable[s] = hit_vec[s];
        end
    end

    // Scan oldest to youngest so that a younger hit overrides an older one.
    always_comb begin
        sel = '0;
        for (int i = NSTG - 1; i >= 0; i--) begin
            if (usable[i]) begin
                sel = SW'(i + 1);
            end
        end
    end

endmodule

// File: rtl/raw_load_stall.sv
// Stall when an operand depends on a load still inside the load window.
module raw_load_stall #(
    parameter int unsigned NSTG       = 3,
    parameter int unsigned LOAD_DEPTH = 1
) (
    input  logic [NSTG-1:0] hit_a,
    input  logic [NSTG-1:0] hit_b,
    input  logic [NSTG-1:0] load_vec,
    output logic            stall
);

    always_comb begin
        stall = 1'b0;
        for (int i = 0; i < NSTG; i++) begin
            if ((i < int'(LOAD_DEPTH)) && load_vec[i] && (hit_a[i] || hit_b[i])) begin
                stall = 1'b1;
            end
        end
    end

endmodule

// File: rtl/raw_hazard_fwd.sv
module raw_hazard_fwd
    import raw_fwd_pkg::*;
#(
    parameter int unsigned AW         = 5,
    parameter bit          WB_BYPASS  = 1'b1,
    parameter int unsigned LOAD_DEPTH = 1
) (
    input  logic [AW-1:0]    src_a_idx,
    input  logic [AW-1:0]    src_b_idx,
    input  logic [AW-1:0]    ex_dst_idx,
    input  logic             ex_wr_en,
    input  logic             ex_is_load,
    input  logic [AW-1:0]    mem_dst_idx,
    input  logic             mem_wr_en,
    input  logic             mem_is_load,
    input  logic [AW-1:0]    wb_dst_idx,
    input  logic             wb_wr_en,
    input  logic             wb_is_load,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic             load_stall,
    output logic             raw_hazard
);

    localparam int unsigned NOPND = 2;

    logic [NUM_STAGES-1:0][AW-1:0] dst_vec;
    logic [NUM_STAGES-1:0]         wen_vec;
    logic [NUM_STAGES-1:0]         ld_vec;
    logic [NOPND-1:0][AW-1:0]      src_vec;
    logic [NOPND-1:0][NUM_STAGES-1:0] hit_q;
    logic [NOPND-1:0][SEL_W-1:0]   sel_vec;

    assign dst_vec[STG_EX]  = ex_dst_idx;
    assign dst_vec[STG_MEM] = mem_dst_idx;
    assign dst_vec[STG_WB]  = wb_dst_idx;
    assign wen_vec[STG_EX]  = ex_wr_en;
    assign wen_vec[STG_MEM] = mem_wr_en;
    assign wen_vec[STG_WB]  = wb_wr_en;
    // A load flag only means something for a stage that writes.
    assign ld_vec[STG_EX]   = ex_is_load  && ex_wr_en;
    assign ld_vec[STG_MEM]  = mem_is_load && mem_wr_en;
    assign ld_vec[STG_WB]   = wb_is_load  && wb_wr_en;

    assign src_vec[0] = src_a_idx;
    assign src_vec[1] = src_b_idx;

    for (genvar op = 0; op < NOPND; op++) begin : g_opnd
        raw_stage_match #(
            .AW   (AW),
            .NSTG (NUM_STAGES)
        ) u_match (
            .src_idx (src_vec[op]),
            .dst_vec (dst_vec),
            .wen_vec (wen_vec),
            .hit_vec (hit_q[op])
        );

        raw_fwd_pick #(
            .NSTG    (NUM_STAGES),
            .USE_OLD (WB_BYPASS)
        ) u_pick (
            .hit_vec (hit_q[op]),
            .sel     (sel_vec[op])
        );
    end

    raw_load_stall #(
        .NSTG       (NUM_STAGES),
        .LOAD_DEPTH (LOAD_DEPTH)
    ) u_stall (
        .hit_a    (hit_q[0]),
        .hit_b    (hit_q[1]),
        .load_vec (ld_vec),
        .stall    (load_stall)
    );

    assign sel_a      = sel_vec[0];
    assign sel_b      = sel_vec[1];
    assign raw_hazard = |{hit_q[0], hit_q[1]};

endmodule

// File: rtl/raw_hazard_fwd_chk.sv
module raw_hazard_fwd_chk #(
    parameter int unsigned AW        = 5,
    parameter bit          WB_BYPASS = 1'b1
) (
    input logic [AW-1:0] src_a_idx,
    input logic [AW-1:0] src_b_idx,
    input logic [AW-1:0] ex_dst_idx,
    input logic          ex_wr_en,
    input logic          ex_is_load,
    input logic [AW-1:0] mem_dst_idx,
    input logic          mem_wr_en,
    input logic [1:0]    sel_a,
    input logic [1:0]    sel_b,
    input logic          load_stall,
    input logic          raw_hazard
);

    always_comb begin
        // R4
        idle_sel_rf_chk: assert (raw_hazard || (sel_a == 2'd0 && sel_b == 2'd0));
        // R2
        zero_src_quiet_chk: assert ((src_a_idx != '0 || sel_a == 2'd0) &&
                                    (src_b_idx != '0 || sel_b == 2'd0));
        // R6
        stall_cause_chk: assert (!load_stall ||
            (raw_hazard && ex_wr_en && ex_is_load &&
             (ex_dst_idx == src_a_idx || ex_dst_idx == src_b_idx)));
        // R3
        wb_oldest_chk: assert (sel_a != 2'd3 ||
            !((ex_wr_en && ex_dst_idx == src_a_idx) || (mem_wr_en && mem_dst_idx == src_a_idx)));
        // R8
        no_wb_path_chk: assert (WB_BYPASS || (sel_a != 2'd3 && sel_b != 2'd3));
        // R1
        mem_flag_chk: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == src_b_idx) || raw_hazard);
    end

endmodule

bind raw_hazard_fwd raw_hazard_fwd_chk #(.AW(AW), .WB_BYPASS(WB_BYPASS)) u_chk (
    .src_a_idx   (src_a_idx),
    .src_b_idx   (src_b_idx),
    .ex_dst_idx  (ex_dst_idx),
    .ex_wr_en    (ex_wr_en),
    .ex_is_load  (ex_is_load),
    .mem_dst_idx (mem_dst_idx),
    .mem_wr_en   (mem_wr_en),
    .sel_a       (sel_a),
    .sel_b       (sel_b),
    .load_stall  (load_stall),
    .raw_hazard  (raw_hazard)
);

// File: tb/raw_hazard_fwd_tb.sv
module raw_hazard_fwd_tb;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic [4:0] a, b, exd, md, wd;
    logic exw, exl, mw, ml, ww, wl;
    logic [1:0] sa, sb, sa2, sb2;
    logic st, hz, st2, hz2;
    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    raw_hazard_fwd u_dut (
        .src_a_idx(a), .src_b_idx(b),
        .ex_dst_idx(exd), .ex_wr_en(exw), .ex_is_load(exl),
        .mem_dst_idx(md), .mem_wr_en(mw), .mem_is_load(ml),
        .wb_dst_idx(wd), .wb_wr_en(ww), .wb_is_load(wl),
        .sel_a(sa), .sel_b(sb), .load_stall(st), .raw_hazard(hz)
    );

    raw_hazard_fwd #(.WB_BYPASS(1'b0)) u_dut_nowb (
        .src_a_idx(a), .src_b_idx(b),
        .ex_dst_idx(exd), .ex_wr_en(exw), .ex_is_load(exl),
        .mem_dst_idx(md), .mem_wr_en(mw), .mem_is_load(ml),
        .wb_dst_idx(wd), .wb_wr_en(ww), .wb_is_load(wl),
        .sel_a(sa2), .sel_b(sb2), .load_stall(st2), .raw_hazard(hz2)
    );

    task automatic drive(input logic [4:0] ia, ib,
                         input logic [4:0] iexd, input logic iexw, iexl,
                         input logic [4:0] imd,  input logic imw,  iml,
                         input logic [4:0] iwd,  input logic iww,  iwl);
        @(negedge clk);
        a = ia; b = ib;
        exd = iexd; exw = iexw; exl = iexl;
        md = imd; mw = imw; ml = iml;
        wd = iwd; ww = iww; wl = iwl;
        #1;
    endtask

    task automatic expect_main(input string tag, input logic [1:0] ea, eb,
                               input logic es, eh);
        total++;
        if (sa !== ea || sb !== eb || st !== es || hz !== eh) begin
            bad++;
            $display("FAIL %s: got sel_a=%0d sel_b=%0d stall=%0b haz=%0b exp %0d %0d %0b %0b",
                     tag, sa, sb, st, hz, ea, eb, es, eh);
        end
    endtask

    task automatic expect_nowb(input string tag, input logic [1:0] ea, eb,
                               input logic eh);
        total++;
        if (sa2 !== ea || sb2 !== eb || hz2 !== eh) begin
            bad++;
            $display("FAIL %s: got sel_a=%0d sel_b=%0d haz=%0b exp %0d %0d %0b",
                     tag, sa2, sb2, hz2, ea, eb, eh);
        end
    endtask

    task automatic t_idle;
        drive(5'd0, 5'd0, 5'd0, 0, 0, 5'd0, 0, 0, 5'd0, 0, 0);
        expect_main("R4 idle all quiet", 2'd0, 2'd0, 1'b0, 1'b0);
        drive(5'd3, 5'd4, 5'd7, 1, 0, 5'd8, 1, 0, 5'd9, 1, 0);
        expect_main("R4 no match defaults to regfile", 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_zero;
        drive(5'd0, 5'd0, 5'd0, 1, 1, 5'd0, 1, 0, 5'd0, 1, 0);
        expect_main("R2 index zero never matches", 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_single;
        drive(5'd5, 5'd6, 5'd5, 1, 0, 5'd1, 0, 0, 5'd2, 0, 0);
        expect_main("R1 rs hits EX", 2'd1, 2'd0, 1'b0, 1'b1);
        drive(5'd5, 5'd6, 5'd1, 0, 0, 5'd1, 0, 0, 5'd6, 1, 0);
        expect_main("R1 rt hits WB", 2'd0, 2'd3, 1'b0, 1'b1);
        drive(5'd5, 5'd6, 5'd1, 0, 0, 5'd6, 1, 0, 5'd2, 0, 0);
        expect_main("R1 rt hits MEM", 2'd0, 2'd2, 1'b0, 1'b1);
    endtask

    task automatic t_disabled;
        drive(5'd5, 5'd6, 5'd5, 0, 1, 5'd6, 0, 0, 5'd5, 0, 0);
        expect_main("R5 disabled stages ignored", 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_priority;
        drive(5'd9, 5'd0, 5'd9, 1, 0, 5'd9, 1, 0, 5'd9, 1, 0);
        expect_main("R3 EX beats MEM and WB", 2'd1, 2'd0, 1'b0, 1'b1);
        drive(5'd9, 5'd0, 5'd4, 1, 0, 5'd9, 1, 0, 5'd9, 1, 0);
        expect_main("R3 MEM beats WB", 2'd2, 2'd0, 1'b0, 1'b1);
    endtask

    task automatic t_split;
        drive(5'd10, 5'd11, 5'd11, 1, 0, 5'd10, 1, 0, 5'd3, 1, 0);
        expect_main("R9 operands independent", 2'd2, 2'd1, 1'b0, 1'b1);
    endtask

    task automatic t_load;
        drive(5'd1, 5'd12, 5'd12, 1, 1, 5'd2, 0, 0, 5'd3, 0, 0);
        expect_main("R6 load in EX stalls", 2'd0, 2'd1, 1'b1, 1'b1);
        drive(5'd12, 5'd1, 5'd2, 1, 0, 5'd12, 1, 1, 5'd3, 0, 0);
        expect_main("R6 load in MEM forwards", 2'd2, 2'd0, 1'b0, 1'b1);
        drive(5'd13, 5'd1, 5'd13, 0, 1, 5'd2, 0, 0, 5'd13, 1, 1);
        expect_main("R6 disabled EX load and WB load no stall", 2'd3, 2'd0, 1'b0, 1'b1);
        drive(5'd14, 5'd15, 5'd16, 1, 1, 5'd2, 0, 0, 5'd3, 0, 0);
        expect_main("R6 unrelated load no stall", 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_comb;
        drive(5'd20, 5'd21, 5'd20, 1, 1, 5'd0, 0, 0, 5'd0, 0, 0);
        expect_main("R7 stall raised", 2'd1, 2'd0, 1'b1, 1'b1);
        exd = 5'd22; #1;
        expect_main("R7 stall drops without a clock edge", 2'd0, 2'd0, 1'b0, 1'b0);
    endtask

    task automatic t_nowb;
        drive(5'd7, 5'd8, 5'd1, 0, 0, 5'd2, 0, 0, 5'd7, 1, 0);
        expect_nowb("R8 WB-only match uses regfile", 2'd0, 2'd0, 1'b1);
        expect_main("R8 reference instance forwards WB", 2'd3, 2'd0, 1'b0, 1'b1);
        drive(5'd7, 5'd8, 5'd8, 1, 0, 5'd7, 1, 0, 5'd7, 1, 0);
        expect_nowb("R8 MEM and EX still forward", 2'd2, 2'd1, 1'b1);
    endtask

    initial begin
        #150000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: got hang exp completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        t_idle();
        t_zero();
        t_single();
        t_disabled();
        t_priority();
        t_split();
        t_load();
        t_comb();
        t_nowb();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule